// File: doc/BRIEF.md
# Shared-Converter Reference Level Refresher

This block holds a bank of reference-level codes and keeps many analog sample-and-hold outputs charged from one shared digital-to-analog converter. A host writes a 12-bit code into any of 32 slots and can read every slot back. A sequencer runs on its own and visits the enabled slots one after another. On each visit it puts the slot's code on the converter bus, waits a programmable settling time, and then pulses the capture strobe that belongs to that slot.

Every held output is refreshed again on every pass, so any charge lost on a hold capacitor is restored. A slot-enable mask drops unused slots from the rotation, which makes each pass shorter. Typically only about a dozen slots carry real levels: driver and sensor thresholds for two logic sets, clock driver rails, a trigger threshold and a sync threshold. After reset no capture strobe fires until the sequencer has finished one whole pass. This keeps the holds from sampling a converter output that has not yet settled to a real code.

Top module: `refdac_refresher`

## Requirements
- R1: While reset is asserted, and right after it is released, `dac_load` and every bit of `hold_strobe` are low, and every slot reads back as code 0.
- R2: A host write (`host_wr_en` high at a rising edge) stores `host_wr_data` into slot `host_addr`. `host_rd_data` always shows the stored code of slot `host_addr`, unchanged.
- R3: The sequencer visits only the slots whose bit i of `slot_enable` is 1. It visits them in ascending index order and wraps from the highest enabled slot back to the lowest. The first visit after leaving idle is the lowest enabled slot at or after the last slot it held, which is slot 0 after reset.
- R4: At each visit `dac_code` takes the stored code of the visited slot, and `dac_load` is high for exactly one cycle. `dac_code` does not change in any cycle where `dac_load` is low.
- R5: Once armed, the strobe of the visited slot (bit i of `hold_strobe` for slot i) goes high exactly `settle_cycles`+1 cycles after `dac_load`. It stays high for one cycle, and no other strobe bit is high at the same time.
- R6: From reset until the sequencer wraps for the first time, no strobe fires. The slots of that first pass are loaded into the converter but not captured.
- R7: A write to a slot changes what `dac_code` shows on that slot's next visit. It does not change the code of a visit already in progress.
- R8: When `slot_enable` is all zeros, the sequencer finishes the visit in progress and then goes idle. While idle it issues no `dac_load` and no strobe.
- R9: Consecutive `dac_load` pulses are exactly `settle_cycles`+3 cycles apart while at least one slot is enabled.
- R10: A write changes only the addressed slot. Neighbouring slots keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 5 | Slot index for host write and read |
| host_wr_data | input | 12 | Code to store |
| host_rd_data | output | 12 | Stored code of slot `host_addr` |
| slot_enable | input | 32 | Bit i enables slot i in the rotation |
| settle_cycles | input | 8 | Settling wait, in clocks |
| dac_code | output | 12 | Code presented to the converter |
| dac_load | output | 1 | One-cycle pulse when a new code is presented |
| hold_strobe | output | 32 | One-hot capture strobes, bit i for slot i |

## Verification
The bench goes after the first pass after reset. A design that arms too early would capture unsettled levels there, and the bench would see a strobe it does not expect. It times the strobe and the next load against the settle count, including a zero settle count, where a counter off by one would move the strobe or stretch the period. It writes slots just before they are visited and while they are being visited. A design that reads the memory at the wrong moment would then show a new code too early or miss it for a whole pass. It also runs a single-slot mask at the top index, and clears the mask in the middle of a visit, where a broken wrap or idle path would hang or keep loading.

// File: rtl/refdac_pkg.sv
package refdac_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PRESENT = 2'd1,
        SEQ_SETTLE  = 2'd2,
        SEQ_ADVANCE = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/refdac_code_bank.sv
module refdac_code_bank #(
    parameter int NUM_SLOTS = 32,
    parameter int CODE_W    = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_data,
    input  logic [SLOT_W-1:0] fetch_addr,
    output logic [CODE_W-1:0] fetch_data
);

    logic [CODE_W-1:0] mem_q [NUM_SLOTS];
    logic [CODE_W-1:0] mem_d [NUM_SLOTS];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data    = mem_q[rd_addr];
    assign fetch_data = mem_q[fetch_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R2

    AST_NEIGHBOUR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != fetch_addr)) |=>
            (mem_q[$past(fetch_addr)] == $past(fetch_data))); // R10

endmodule

// File: rtl/refdac_slot_picker.sv
module refdac_slot_picker #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [NUM_SLOTS-1:0] enable_mask,
    input  logic                 include_cur,
    output logic [SLOT_W-1:0]    next_slot,
    output logic                 any_enabled,
    output logic                 wrapped
);

    int          cand;
    logic        found;
    logic [SLOT_W-1:0] cand_w;

    always_comb begin
        next_slot   = cur_slot;
        any_enabled = |enable_mask;
        wrapped     = 1'b0;
        found       = 1'b0;
        cand        = 0;
        cand_w      = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cand = int'(cur_slot) + i + (include_cur ? 0 : 1);
            if (cand >= NUM_SLOTS) begin
                cand = cand - NUM_SLOTS;
            end
            cand_w = cand[SLOT_W-1:0];
            if (!found && enable_mask[cand_w]) begin
                found     = 1'b1;
                next_slot = cand_w;
                wrapped   = !include_cur && (cand_w <= cur_slot);
            end
        end
    end

endmodule

// File: rtl/refdac_sequencer.sv
module refdac_sequencer
    import refdac_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int CODE_W    = 12,
    parameter int SETTLE_W  = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_enable,
    input  logic [SETTLE_W-1:0]  settle_cycles,
    output logic [SLOT_W-1:0]    fetch_addr,
    input  logic [CODE_W-1:0]    fetch_data,
    output logic [CODE_W-1:0]    dac_code,
    output logic                 dac_load,
    output logic [NUM_SLOTS-1:0] hold_strobe
);

    typedef struct packed {
        seq_phase_e           phase;
        logic [SLOT_W-1:0]    slot;
        logic [SETTLE_W-1:0]  cnt;
        logic                 armed;
        logic [CODE_W-1:0]    code;
        logic                 load;
        logic [NUM_SLOTS-1:0] strobe;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    logic [SLOT_W-1:0] pick_next;
    logic              pick_any;
    logic              pick_wrap;
    logic              pick_incl;

    assign pick_incl = (r_q.phase == SEQ_IDLE);

    refdac_slot_picker #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_picker (
        .cur_slot    (r_q.slot),
        .enable_mask (slot_enable),
        .include_cur (pick_incl),
        .next_slot   (pick_next),
        .any_enabled (pick_any),
        .wrapped     (pick_wrap)
    );

    always_comb begin
        r_d        = r_q;
        r_d.load   = 1'b0;
        r_d.strobe = '0;
        unique case (r_q.phase)
            SEQ_IDLE: begin
                if (pick_any) begin
                    r_d.slot  = pick_next;
                    r_d.phase = SEQ_PRESENT;
                end
            end
            SEQ_PRESENT: begin
                r_d.code  = fetch_data;
                r_d.load  = 1'b1;
                r_d.cnt   = '0;
                r_d.phase = SEQ_SETTLE;
            end
            SEQ_SETTLE: begin
                if (r_q.cnt >= settle_cycles) begin
                    r_d.strobe[r_q.slot] = r_q.armed;
                    r_d.phase            = SEQ_ADVANCE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SEQ_ADVANCE: begin
                if (pick_any) begin
                    r_d.slot  = pick_next;
                    r_d.phase = SEQ_PRESENT;
                    if (pick_wrap) begin
                        r_d.armed = 1'b1;
                    end
                end else begin
                    r_d.phase = SEQ_IDLE;
                end
            end
            default: r_d.phase = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: SEQ_IDLE, slot: '0, cnt: '0, armed: 1'b0,
                     code: '0, load: 1'b0, strobe: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_addr  = r_q.slot;
    assign dac_code    = r_q.code;
    assign dac_load    = r_q.load;
    assign hold_strobe = r_q.strobe;

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load); // R4

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> $stable(dac_code)); // R4

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hold_strobe)); // R5

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_strobe) |=> (hold_strobe == '0)); // R5

    AST_NO_STROBE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.armed |-> (hold_strobe == '0)); // R6

    AST_LOAD_NOT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> (hold_strobe == '0)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.phase == SEQ_IDLE) && (slot_enable == '0)) |=> !dac_load); // R8

endmodule

// File: rtl/refdac_refresher.sv
module refdac_refresher #(
    parameter int NUM_SLOTS = 32,
    parameter int CODE_W    = 12,
    parameter int SETTLE_W  = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr_en,
    input  logic [SLOT_W-1:0]    host_addr,
    input  logic [CODE_W-1:0]    host_wr_data,
    output logic [CODE_W-1:0]    host_rd_data,
    input  logic [NUM_SLOTS-1:0] slot_enable,
    input  logic [SETTLE_W-1:0]  settle_cycles,
    output logic [CODE_W-1:0]    dac_code,
    output logic                 dac_load,
    output logic [NUM_SLOTS-1:0] hold_strobe
);

    logic [SLOT_W-1:0] fetch_addr;
    logic [CODE_W-1:0] fetch_data;

    refdac_code_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en),
        .wr_addr    (host_addr),
        .wr_data    (host_wr_data),
        .rd_addr    (host_addr),
        .rd_data    (host_rd_data),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data)
    );

    refdac_sequencer #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W),
        .SETTLE_W  (SETTLE_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_enable   (slot_enable),
        .settle_cycles (settle_cycles),
        .fetch_addr    (fetch_addr),
        .fetch_data    (fetch_data),
        .dac_code      (dac_code),
        .dac_load      (dac_load),
        .hold_strobe   (hold_strobe)
    );

endmodule

// File: tb/tb_refdac_refresher.sv
module tb_refdac_refresher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [11:0] host_wr_data = '0;
    logic [11:0] host_rd_data;
    logic [31:0] slot_enable = '0;
    logic [7:0]  settle_cycles = '0;
    logic [11:0] dac_code;
    logic        dac_load;
    logic [31:0] hold_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int settle_v = 0;
    logic [11:0] code_mem [32];

    always #5 clk = ~clk;

    refdac_refresher dut (
        .clk (clk), .rst_n (rst_n), .host_wr_en (host_wr_en),
        .host_addr (host_addr), .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data), .slot_enable (slot_enable),
        .settle_cycles (settle_cycles), .dac_code (dac_code),
        .dac_load (dac_load), .hold_strobe (hold_strobe)
    );

    // write table: {slot, code}; slots 8 and 9 are neighbours for R10
    localparam logic [16:0] WR_TAB [8] = '{
        {5'd3,  12'hABC}, {5'd8,  12'h123}, {5'd9,  12'h456}, {5'd31, 12'hFFF},
        {5'd0,  12'h001}, {5'd17, 12'h800}, {5'd4,  12'h000}, {5'd30, 12'h7FE}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] code_of(input int s);
        return 12'((s * 149 + 7) & 12'hFFF);
    endfunction

    function automatic int next_en(input int from, input logic [31:0] m);
        for (int i = 0; i < 32; i++) begin
            if (m[(from + i) % 32]) return (from + i) % 32;
        end
        return -1;
    endfunction

    task automatic host_write(input int s, input logic [11:0] c);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 5'(s); host_wr_data = c;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic wait_load();
        while (!dac_load) @(negedge clk);
    endtask

    // entered at the negedge where dac_load is seen high; leaves at the next one
    task automatic visit(input int s, input bit armed_exp);
        bit quiet = 1'b1;
        logic [31:0] exp_strobe;
        exp_strobe = armed_exp ? (32'd1 << s) : 32'd0;
        chk(dac_code == code_mem[s], "R3/R4 visited slot code", 32'(dac_code), 32'(code_mem[s]));
        for (int j = 1; j <= settle_v + 3; j++) begin
            @(negedge clk);
            host_wr_en = 1'b0;
            if (j == 1)
                chk(!dac_load, "R4 load lasts one cycle", 32'(dac_load), 32'd0);
            if (j == settle_v + 1)
                chk(hold_strobe == exp_strobe, armed_exp ? "R5 strobe timing" : "R6 no strobe first pass",
                    hold_strobe, exp_strobe);
            else if (hold_strobe != 0)
                quiet = 1'b0;
            if (j == settle_v + 3)
                chk(dac_load, "R9 visit period", 32'(dac_load), 32'd1);
        end
        chk(quiet, "R5 strobe only in its cycle", 32'(quiet), 32'd1);
    endtask

    task automatic run_passes(input logic [31:0] m, input int start, input int visits,
                              input bit armed_exp);
        int s = start;
        for (int v = 0; v < visits; v++) begin
            visit(s, armed_exp);
            s = next_en(s + 1, m);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] m1;
        int loads;
        bit ok;
        int s;
        for (int i = 0; i < 32; i++) code_mem[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(hold_strobe == 0 && !dac_load, "R1 outputs low in reset",
            {dac_load, hold_strobe[30:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hold_strobe == 0 && !dac_load, "R1 outputs low after reset",
            {dac_load, hold_strobe[30:0]}, 32'd0);
        ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            host_addr = 5'(i); #1;
            if (host_rd_data != 0) ok = 1'b0;
        end
        chk(ok, "R1 all codes zero after reset", 32'(ok), 32'd1);

        // R2 / R10: table of writes then read-back
        for (int k = 0; k < 8; k++) begin
            host_write(int'(WR_TAB[k][16:12]), WR_TAB[k][11:0]);
        end
        for (int k = 0; k < 8; k++) begin
            host_addr = WR_TAB[k][16:12]; #1;
            chk(host_rd_data == WR_TAB[k][11:0], "R2 read-back of written slot",
                32'(host_rd_data), 32'(WR_TAB[k][11:0]));
        end
        host_addr = 5'd8; #1;
        chk(host_rd_data == 12'h123, "R10 neighbour slot 8 kept", 32'(host_rd_data), 32'h123);
        host_addr = 5'd10; #1;
        chk(host_rd_data == 12'h000, "R10 unwritten slot 10 kept", 32'(host_rd_data), 32'h0);

        // load distinct codes everywhere
        for (int i = 0; i < 32; i++) begin
            host_write(i, code_of(i));
            code_mem[i] = code_of(i);
        end

        // R3/R5/R6/R9: sparse mask, settle 2
        m1 = (32'd1 << 0) | (32'd1 << 5) | (32'd1 << 6) | (32'd1 << 10) |
             (32'd1 << 13) | (32'd1 << 31);
        settle_v = 2; settle_cycles = 8'd2;
        @(negedge clk);
        slot_enable = m1;
        wait_load();
        run_passes(m1, 0, 6, 1'b0);   // R6 first pass unarmed
        run_passes(m1, 0, 6, 1'b1);   // second pass armed

        // R7: writes around visits
        host_wr_en = 1'b1; host_addr = 5'd0; host_wr_data = 12'h5A5;
        visit(0, 1'b1);               // in-progress visit keeps old code
        code_mem[0] = 12'h5A5;
        host_wr_en = 1'b1; host_addr = 5'd10; host_wr_data = 12'h3C3;
        visit(5, 1'b1);
        code_mem[10] = 12'h3C3;
        run_passes(m1, 6, 4, 1'b1);   // slot 10 shows new code this pass (R7)
        visit(0, 1'b1);               // slot 0 shows new code next pass (R7)
        run_passes(m1, 5, 5, 1'b1);

        // R8: clear mask mid-visit
        slot_enable = '0;
        repeat (settle_v + 4) @(negedge clk);
        loads = 0; ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dac_load) loads++;
            if (hold_strobe != 0) ok = 1'b0;
        end
        chk(loads == 0, "R8 no load with empty mask", 32'(loads), 32'd0);
        chk(ok, "R8 no strobe with empty mask", 32'(ok), 32'd1);

        // single top slot, settle 0: every advance wraps
        settle_v = 0; settle_cycles = 8'd0;
        slot_enable = 32'h8000_0000;
        wait_load();
        run_passes(32'h8000_0000, 31, 3, 1'b1);

        // settle 5 with two slots
        slot_enable = 32'h0000_0006;
        settle_v = 5; settle_cycles = 8'd5;
        repeat (4) @(negedge clk);
        wait_load();
        chk(dac_code == code_mem[1] || dac_code == code_mem[2], "R3 lands on enabled slot",
            32'(dac_code), 32'(code_mem[1]));
        s = (dac_code == code_mem[1]) ? 1 : 2;
        run_passes(32'h0000_0006, s, 4, 1'b1);

        // R1/R6: reset during operation
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(hold_strobe == 0 && !dac_load, "R1 outputs low on mid-run reset",
            {dac_load, hold_strobe[30:0]}, 32'd0);
        for (int i = 0; i < 32; i++) code_mem[i] = '0;
        host_addr = 5'd31; #1;
        chk(host_rd_data == 0, "R1 code cleared by reset", 32'(host_rd_data), 32'd0);
        rst_n = 1'b1;
        wait_load();
        run_passes(32'h0000_0006, 1, 2, 1'b0);  // R6 unarmed again
        run_passes(32'h0000_0006, 1, 2, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule